// File: doc/BRIEF.md
# External Bus Address/Data Port Multiplexer

This block sits between an 8-bit microcontroller core and its two external-bus ports. When no external bus cycle is running, both ports show their port-register latch values and use quasi-bidirectional drive enables. When the core starts a bus cycle, the low port (port 0) is time-multiplexed. In the first clock it carries the low address byte and an address-latch strobe is high. In the second clock it either drives write data or is released so that an opcode byte or a data byte can be read in. The high port (port 2) carries the high address byte for the whole cycle.

A bus cycle is requested with a one-clock `start` pulse and a two-bit kind: code fetch, data read or data write. For a code fetch, the address is the program counter. For an external data move, the low byte comes from `data_lo`. The high byte is then either the data-pointer high byte or the port-2 register, chosen by `addr16`. All cycle parameters are captured when the cycle is accepted. Bytes read from port 0 are captured on the clock edge that ends the read or fetch strobe.

Top module: `xbus_port_mux`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, no cycle is in progress. `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `rdata_valid` is 0 and `rdata` is 0.
- R2: When no cycle is in progress, `p0_out` equals `p0_latch`. `p0_oe` is 1 unless `p0_latch` is 8'hFF. `p2_out` equals `p2_latch` and `p2_oe[i]` is the inverse of `p2_latch[i]`.
- R3: A `start` with kind 2'b00 (fetch), 2'b01 (read) or 2'b10 (write), seen on a clock edge while no cycle is in progress, begins a cycle. The cycle has one address clock (`ale`=1) and then one data clock, and it returns to idle after that. A `start` during a cycle, or a `start` with kind 2'b11, is ignored.
- R4: In the address clock, `p0_oe` is 1. `p0_out` is the captured `pc[7:0]` for a fetch and the captured `data_lo` for a read or write.
- R5: For a fetch, `p2_out` is the captured `pc[15:8]` in both clocks of the cycle. During any cycle `p2_oe` is 8'hFF.
- R6: For a read or write, `p2_out` is the captured `dptr_hi` when `addr16` was 1 at the start, and the captured `p2_latch` when it was 0.
- R7: In the data clock of a fetch, `psen_n` is 0 and `p0_oe` is 0.
- R8: In the data clock of a read, `rd_n` is 0, `p0_oe` is 0 and `p0_out` is 8'hFF.
- R9: In the data clock of a write, `wr_n` is 0, `p0_oe` is 1 and `p0_out` is the `wdata` captured at the start.
- R10: At the edge that ends the data clock of a fetch or read, `p0_in` is captured into `rdata`, which then holds. `rdata_valid` is 1 for exactly the following clock.
- R11: At most one of `ale`, `!psen_n`, `!rd_n` and `!wr_n` is active in any clock, and `ale` is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a bus cycle |
| kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 none |
| addr16 | input | 1 | Data move uses the 16-bit data pointer (1) or 8-bit indirect (0) |
| pc | input | 16 | Program counter |
| dptr_hi | input | 8 | Data-pointer high byte |
| data_lo | input | 8 | Low address byte for data moves |
| wdata | input | 8 | Write data |
| p0_latch | input | 8 | Port-0 register latch |
| p2_latch | input | 8 | Port-2 register latch |
| p0_in | input | 8 | Port-0 pin values |
| p0_out | output | 8 | Port-0 output value |
| p0_oe | output | 1 | Shared drive enable for all port-0 bits |
| p2_out | output | 8 | Port-2 output value |
| p2_oe | output | 8 | Per-bit drive enables for port 2 |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Last captured port-0 byte |
| rdata_valid | output | 1 | One-clock pulse after a capture |

## Verification
The assertions check on every clock that the strobes are mutually exclusive and that `ale` lasts one clock. They also check that port 0 is released whenever a read strobe is low and driven whenever the write strobe is low, that port 2 holds steady across the data clock, and that a valid pulse only follows a read or fetch strobe. Only the bench's reference model can show the actual values: the address bytes, the choice between the data-pointer and the register source for port 2, the captured read byte, the idle quasi-bidirectional enables, and the rejection of requests during a cycle or with the unused kind.

// File: rtl/xbus_port_mux.sv
module xbus_port_mux #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     kind,
  input  logic           addr16,
  input  logic [2*W-1:0] pc,
  input  logic [W-1:0]   dptr_hi,
  input  logic [W-1:0]   data_lo,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   p0_latch,
  input  logic [W-1:0]   p2_latch,
  input  logic [W-1:0]   p0_in,
  output logic [W-1:0]   p0_out,
  output logic           p0_oe,
  output logic [W-1:0]   p2_out,
  output logic [W-1:0]   p2_oe,
  output logic           ale,
  output logic           psen_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic [W-1:0]   rdata,
  output logic           rdata_valid
);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;
  localparam logic [1:0] K_NONE  = 2'b11;
  localparam logic [W-1:0] ONES = '1;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} ph_t;

  ph_t        ph;
  logic [1:0] kind_q;
  logic [W-1:0] lo_q, hi_q, wd_q;

  wire go    = (ph == PH_IDLE) && start && (kind != K_NONE);
  wire busy  = (ph != PH_IDLE);
  wire in_d  = (ph == PH_DATA);
  wire d_wr  = in_d && (kind_q == K_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      kind_q      <= K_FETCH;
      lo_q        <= '0;
      hi_q        <= '0;
      wd_q        <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          ph     <= PH_ADDR;
          kind_q <= kind;
          wd_q   <= wdata;
          lo_q   <= (kind == K_FETCH) ? pc[W-1:0] : data_lo;
          hi_q   <= (kind == K_FETCH) ? pc[2*W-1:W] : (addr16 ? dptr_hi : p2_latch);
        end
        PH_ADDR: ph <= PH_DATA;
        default: begin
          ph <= PH_IDLE;
          if (kind_q != K_WRITE) begin
            rdata       <= p0_in;
            rdata_valid <= 1'b1;
          end
        end
      endcase
    end
  end

  assign ale    = (ph == PH_ADDR);
  assign psen_n = !(in_d && kind_q == K_FETCH);
  assign rd_n   = !(in_d && kind_q == K_READ);
  assign wr_n   = !d_wr;

  assign p0_out = ale ? lo_q : in_d ? (d_wr ? wd_q : ONES) : p0_latch;
  assign p0_oe  = ale || d_wr || (!busy && p0_latch != ONES);
  assign p2_out = busy ? hi_q : p2_latch;
  assign p2_oe  = busy ? ONES : ~p2_latch;

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale, !psen_n, !rd_n, !wr_n}));
  p_ale_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_ale_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!psen_n || !rd_n || !wr_n));
  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe);
  p_write_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);
  p_p2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |-> ($stable(p2_out) && p2_oe == ONES));
  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!rd_n || !psen_n));
endmodule

// File: tb/xbus_port_mux_bench.sv
module xbus_port_mux_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, addr16 = 0;
  logic [1:0] kind = 0;
  logic [15:0] pc = 0;
  logic [7:0] dptr_hi = 0, data_lo = 0, wdata = 0, p0_latch = 8'hFF, p2_latch = 8'hFF, p0_in = 0;
  logic [7:0] p0_out, p2_out, p2_oe, rdata;
  logic p0_oe, ale, psen_n, rd_n, wr_n, rdata_valid;

  int checks = 0, errors = 0, cyc = 0;
  bit run_chk = 0, done = 0;

  xbus_port_mux u_xbus_port_mux (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .addr16(addr16),
    .pc(pc), .dptr_hi(dptr_hi), .data_lo(data_lo), .wdata(wdata),
    .p0_latch(p0_latch), .p2_latch(p2_latch), .p0_in(p0_in),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .p2_oe(p2_oe),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rdata(rdata), .rdata_valid(rdata_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int m_ph = 0, m_kind = 0;
  int m_lo = 0, m_hi = 0, m_wd = 0, m_rdata = 0, m_rv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rdata = 0; m_rv = 0;
    end else begin
      m_rv = 0;
      if (m_ph == 0) begin
        if (start && kind != 3) begin
          m_kind = kind; m_wd = wdata;
          m_lo = (kind == 0) ? pc % 256 : data_lo;
          m_hi = (kind == 0) ? pc / 256 : (addr16 ? dptr_hi : p2_latch);
          m_ph = 1;
        end
      end else if (m_ph == 1) m_ph = 2;
      else begin
        if (m_kind != 2) begin m_rdata = p0_in; m_rv = 1; end
        m_ph = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (run_chk) begin
      int e_p0, e_oe, e_p2, e_p2oe;
      string t_p0, t_oe, t_p2;
      if (m_ph == 0) begin
        e_p0 = p0_latch; e_oe = (p0_latch != 8'hFF); e_p2 = p2_latch; e_p2oe = ~p2_latch & 8'hFF;
        t_p0 = "R2"; t_oe = "R2"; t_p2 = "R2";
      end else begin
        e_p2 = m_hi; e_p2oe = 8'hFF; t_p2 = (m_kind == 0) ? "R5" : "R6";
        if (m_ph == 1) begin
          e_p0 = m_lo; e_oe = 1; t_p0 = "R4"; t_oe = "R4";
        end else if (m_kind == 2) begin
          e_p0 = m_wd; e_oe = 1; t_p0 = "R9"; t_oe = "R9";
        end else begin
          e_p0 = 8'hFF; e_oe = 0; t_p0 = "R8"; t_oe = (m_kind == 0) ? "R7" : "R8";
        end
      end
      chk("R3 ale", ale, m_ph == 1);
      chk({t_p0, " p0_out"}, p0_out, e_p0);
      chk({t_oe, " p0_oe"}, p0_oe, e_oe);
      chk({t_p2, " p2_out"}, p2_out, e_p2);
      chk({(m_ph == 0) ? "R2" : "R5", " p2_oe"}, p2_oe, e_p2oe);
      chk("R7 psen_n", psen_n, !(m_ph == 2 && m_kind == 0));
      chk("R8 rd_n", rd_n, !(m_ph == 2 && m_kind == 1));
      chk("R9 wr_n", wr_n, !(m_ph == 2 && m_kind == 2));
      chk("R10 rdata", rdata, m_rdata);
      chk("R10 rdata_valid", rdata_valid, m_rv);
      chk("R11 strobe exclusive", $countones({ale, !psen_n, !rd_n, !wr_n}) <= 1, 1);
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit s, input int k, input bit a16);
    @(negedge clk); #1;
    start = s; kind = k[1:0]; addr16 = a16;
    pc = $urandom; dptr_hi = $urandom; data_lo = $urandom; wdata = $urandom;
    p0_latch = $urandom; p2_latch = $urandom; p0_in = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ale in reset", ale, 0);
    chk("R1 psen_n in reset", psen_n, 1);
    chk("R1 rd_n in reset", rd_n, 1);
    chk("R1 wr_n in reset", wr_n, 1);
    chk("R1 rdata_valid in reset", rdata_valid, 0);
    chk("R1 rdata in reset", rdata, 0);
    #1 rst_n = 1;
    run_chk = 1;
    // directed: each kind, both addressing modes, start held during cycle, unused kind
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(0, 0, 0);
    step(1, 1, 1); step(0, 0, 0); step(0, 0, 0);
    step(1, 1, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 2, 1); step(1, 2, 1); step(1, 2, 1);
    step(1, 2, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 3, 1); step(1, 3, 0); step(0, 0, 0);
    @(negedge clk); #1 p0_latch = 8'hFF; p2_latch = 8'hFF; start = 0;
    @(negedge clk); #1 p0_latch = 8'hFE; p2_latch = 8'h0F;
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) != 0, $urandom % 4, $urandom % 2);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule